// File: doc/BRIEF.md
# Opcode Command Controller with FIFO Test Mode

This block sits behind one opcode register on a simple register bus. Software writes a 16-bit command word there. The controller looks only at the upper byte of that word and ignores the lower byte. A command can select one of four acquisition modes, switch the output FIFO into or out of a memory test mode, or ask for the test-mode status.

Mode commands have side effects. A test-mode change clears the FIFO. An acquisition-mode change clears the FIFO and also resets the time digitisers. Each of these effects is a one-cycle pulse.

In normal operation the FIFO is fed from the digitiser data path. In test mode it is fed from the bus instead. Software first writes the high half of the test word, then writes the low half, and the write of the low half pushes the whole word.

A status request puts the controller into a wait state. The wait ends only when the reply is read at the opcode address. The FIFO storage and the digitisers are not part of this block; they are reached only through its ports.

Top module: `opcode_ctrl`

## Requirements
- R1: After reset, `acq_mode_o` is 3 (continuous storage), and `test_mode_o`, `busy_o`, `fifo_clr_o`, `dig_rst_o` and `fifo_we_o` are all 0.
- R2: A command with upper byte 0x01 sets `test_mode_o` to 1. In the following cycle, `fifo_clr_o` pulses high for one cycle and `dig_rst_o` stays low.
- R3: A command with upper byte 0x02 sets `test_mode_o` to 0. In the following cycle, `fifo_clr_o` pulses high for one cycle and `dig_rst_o` stays low.
- R4: Upper bytes 0x10, 0x11, 0x12 and 0x13 set `acq_mode_o` to 0 (stop-trigger matching), 1 (start-trigger matching), 2 (start gating) and 3 (continuous storage). In the following cycle, `fifo_clr_o` and `dig_rst_o` both pulse high for one cycle.
- R5: The lower byte of a command word has no effect on the result.
- R6: A command with upper byte 0x03 raises `busy_o` from the next cycle. While busy, a read at the opcode address returns `{15'b0, test_mode_o}` on `bus_rdata_o`. `busy_o` drops in the cycle after that read. At all other times `bus_rdata_o` is 0.
- R7: While `busy_o` is high, writes to the opcode address change no state and produce no pulses.
- R8: An upper byte that is not listed above changes no state and produces no pulses.
- R9: With test mode off, `dig_wr_i` pushes `dig_data_i` to the FIFO one cycle later. In that cycle `fifo_we_o` is high and `fifo_wdata_o` holds the word. Bus writes to the test-word registers push nothing.
- R10: With test mode on, a bus write to address 1 stores the high half of the test word. A bus write to address 2 pushes `{high, low}` one cycle later, where low is the written data. Digitiser writes are dropped.
- R11: A FIFO write whose source write falls in the same cycle as an accepted clearing command is dropped. `fifo_we_o` and `fifo_clr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | ADDR_W | Register address: 0 opcode, 1 test high, 2 test low |
| bus_wdata_i | input | DATA_W | Bus write data |
| bus_rdata_o | output | DATA_W | Status reply data |
| busy_o | output | 1 | Waiting for the status reply to be read |
| acq_mode_o | output | 2 | Acquisition mode code |
| test_mode_o | output | 1 | 1 when the FIFO is fed from the bus test word |
| fifo_clr_o | output | 1 | FIFO clear pulse |
| dig_rst_o | output | 1 | Digitiser reset pulse |
| dig_wr_i | input | 1 | Digitiser word valid |
| dig_data_i | input | 2*DATA_W | Digitiser word |
| fifo_we_o | output | 1 | FIFO write enable |
| fifo_wdata_o | output | 2*DATA_W | FIFO write data |

## Verification
A clearing command and a FIFO write can fall in the same cycle. The bench provokes this by raising `dig_wr_i` in the same cycle as an accepted acquisition-mode command. It then checks that the clear pulse appears in the next cycle and that no write enable comes with it.

A second overlap is an opcode write arriving in the same cycle as the status read that releases the wait. That write is judged ignored: the bench checks that no pulse follows it and that the mode outputs do not change.

// File: rtl/opc_pkg.sv
package opc_pkg;
  typedef enum logic [1:0] {
    ACQ_STOP_MATCH  = 2'd0,
    ACQ_START_MATCH = 2'd1,
    ACQ_START_GATE  = 2'd2,
    ACQ_CONTINUOUS  = 2'd3
  } acq_mode_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_TEST_ON,
    CMD_TEST_OFF,
    CMD_STATUS,
    CMD_ACQ
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    acq_mode_e mode;
  } cmd_t;

  localparam logic [7:0] OPC_TEST_ON  = 8'h01;
  localparam logic [7:0] OPC_TEST_OFF = 8'h02;
  localparam logic [7:0] OPC_STATUS   = 8'h03;
  localparam logic [5:0] OPC_ACQ_HI   = 6'b000100; // 0x10..0x13
endpackage

// File: rtl/opc_decode.sv
module opc_decode
  import opc_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o.kind = CMD_NONE;
    cmd_o.mode = acq_mode_e'(code_i[1:0]);
    if (code_i[7:2] == OPC_ACQ_HI) begin
      cmd_o.kind = CMD_ACQ;
    end else begin
      unique case (code_i)
        OPC_TEST_ON:  cmd_o.kind = CMD_TEST_ON;
        OPC_TEST_OFF: cmd_o.kind = CMD_TEST_OFF;
        OPC_STATUS:   cmd_o.kind = CMD_STATUS;
        default:      cmd_o.kind = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/opc_state.sv
module opc_state
  import opc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_valid_i,
  input  cmd_t      cmd_i,
  input  logic      release_i,
  output logic      clr_now_o,
  output logic      test_mode_o,
  output acq_mode_e acq_mode_o,
  output logic      busy_o,
  output logic      fifo_clr_o,
  output logic      dig_rst_o
);
  logic take;
  assign take = cmd_valid_i && !busy_o;

  always_comb begin
    clr_now_o = 1'b0;
    if (take) begin
      clr_now_o = (cmd_i.kind == CMD_TEST_ON) || (cmd_i.kind == CMD_TEST_OFF) ||
                  (cmd_i.kind == CMD_ACQ);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_mode_o <= 1'b0;
      acq_mode_o  <= ACQ_CONTINUOUS;
      busy_o      <= 1'b0;
      fifo_clr_o  <= 1'b0;
      dig_rst_o   <= 1'b0;
    end else begin
      fifo_clr_o <= clr_now_o;
      dig_rst_o  <= take && (cmd_i.kind == CMD_ACQ);
      if (busy_o && release_i) busy_o <= 1'b0;
      if (take) begin
        unique case (cmd_i.kind)
          CMD_TEST_ON:  test_mode_o <= 1'b1;
          CMD_TEST_OFF: test_mode_o <= 1'b0;
          CMD_STATUS:   busy_o      <= 1'b1;
          CMD_ACQ:      acq_mode_o  <= cmd_i.mode;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/opc_fifo_mux.sv
module opc_fifo_mux #(
  parameter int DATA_W = 16,
  localparam int FIFO_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_mode_i,
  input  logic              drop_i,
  input  logic              hi_we_i,
  input  logic              lo_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dig_wr_i,
  input  logic [FIFO_W-1:0] dig_data_i,
  output logic              fifo_we_o,
  output logic [FIFO_W-1:0] fifo_wdata_o
);
  logic [DATA_W-1:0] tw_hi_q;
  logic              src_we;
  logic [FIFO_W-1:0] src_data;

  always_comb begin
    if (test_mode_i) begin
      src_we   = lo_we_i;
      src_data = {tw_hi_q, wdata_i};
    end else begin
      src_we   = dig_wr_i;
      src_data = dig_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tw_hi_q      <= '0;
      fifo_we_o    <= 1'b0;
      fifo_wdata_o <= '0;
    end else begin
      if (hi_we_i) tw_hi_q <= wdata_i;
      // a word racing a clear belongs to the old contents
      fifo_we_o <= src_we && !drop_i;
      if (src_we && !drop_i) fifo_wdata_o <= src_data;
    end
  end
endmodule

// File: rtl/opcode_ctrl.sv
module opcode_ctrl
  import opc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  parameter int OPC_ADDR = 0,
  parameter int HI_ADDR  = 1,
  parameter int LO_ADDR  = 2,
  localparam int FIFO_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              busy_o,
  output logic [1:0]        acq_mode_o,
  output logic              test_mode_o,
  output logic              fifo_clr_o,
  output logic              dig_rst_o,
  input  logic              dig_wr_i,
  input  logic [FIFO_W-1:0] dig_data_i,
  output logic              fifo_we_o,
  output logic [FIFO_W-1:0] fifo_wdata_o
);
  logic      at_opc, at_hi, at_lo, clr_now;
  cmd_t      cmd;
  acq_mode_e acq_mode;

  assign at_opc = bus_addr_i == ADDR_W'(OPC_ADDR);
  assign at_hi  = bus_addr_i == ADDR_W'(HI_ADDR);
  assign at_lo  = bus_addr_i == ADDR_W'(LO_ADDR);

  opc_decode i_decode (
    .code_i (bus_wdata_i[DATA_W-1 -: 8]),
    .cmd_o  (cmd)
  );

  opc_state i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (bus_wr_i && at_opc),
    .cmd_i       (cmd),
    .release_i   (bus_rd_i && at_opc),
    .clr_now_o   (clr_now),
    .test_mode_o (test_mode_o),
    .acq_mode_o  (acq_mode),
    .busy_o      (busy_o),
    .fifo_clr_o  (fifo_clr_o),
    .dig_rst_o   (dig_rst_o)
  );
  assign acq_mode_o = acq_mode;

  opc_fifo_mux #(.DATA_W(DATA_W)) i_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .test_mode_i  (test_mode_o),
    .drop_i       (clr_now),
    .hi_we_i      (bus_wr_i && at_hi),
    .lo_we_i      (bus_wr_i && at_lo),
    .wdata_i      (bus_wdata_i),
    .dig_wr_i     (dig_wr_i),
    .dig_data_i   (dig_data_i),
    .fifo_we_o    (fifo_we_o),
    .fifo_wdata_o (fifo_wdata_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (busy_o && bus_rd_i && at_opc) bus_rdata_o[0] = test_mode_o;
  end
endmodule

// File: rtl/opcode_ctrl_chk.sv
module opcode_ctrl_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2,
  parameter int OPC_ADDR = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              busy_o,
  input logic [1:0]        acq_mode_o,
  input logic              test_mode_o,
  input logic              fifo_clr_o,
  input logic              dig_rst_o,
  input logic              fifo_we_o
);
  logic rd_opc;
  assign rd_opc = bus_rd_i && (bus_addr_i == ADDR_W'(OPC_ADDR));

  p_test_chg_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_mode_o) |-> fifo_clr_o && !dig_rst_o);

  p_acq_chg_resets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acq_mode_o) |-> dig_rst_o && fifo_clr_o);

  p_rst_needs_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_rst_o |-> fifo_clr_o);

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rd_opc |=> !busy_o);

  p_hold_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !rd_opc |=> busy_o);

  p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:1] == '0);

  p_busy_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(test_mode_o) && $stable(acq_mode_o) && !fifo_clr_o);

  p_no_we_on_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_we_o && fifo_clr_o));
endmodule

bind opcode_ctrl opcode_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_ADDR(OPC_ADDR)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .busy_o      (busy_o),
  .acq_mode_o  (acq_mode_o),
  .test_mode_o (test_mode_o),
  .fifo_clr_o  (fifo_clr_o),
  .dig_rst_o   (dig_rst_o),
  .fifo_we_o   (fifo_we_o)
);

// File: tb/test_opcode_ctrl.sv
`timescale 1ns/1ps
module test_opcode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        busy, test_mode, fifo_clr, dig_rst, dig_wr = 1'b0, fifo_we;
  logic [1:0]  acq_mode;
  logic [31:0] dig_data = '0, fifo_wdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opcode_ctrl i_opcode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .busy_o(busy), .acq_mode_o(acq_mode), .test_mode_o(test_mode),
    .fifo_clr_o(fifo_clr), .dig_rst_o(dig_rst), .dig_wr_i(dig_wr),
    .dig_data_i(dig_data), .fifo_we_o(fifo_we), .fifo_wdata_o(fifo_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle, returns at the next negedge with strobes dropped
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [15:0] d, input logic dw, input logic [31:0] dd);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    dig_wr = dw; dig_data = dd;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; dig_wr = 0;
  endtask

  // {opcode, exp test, exp acq, exp clr, exp rst}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {16'h1000, 1'b0, 2'd0, 1'b1, 1'b1},
    {16'h11AB, 1'b0, 2'd1, 1'b1, 1'b1},
    {16'h12FF, 1'b0, 2'd2, 1'b1, 1'b1},
    {16'h0155, 1'b1, 2'd2, 1'b1, 1'b0},
    {16'h7700, 1'b1, 2'd2, 1'b0, 1'b0},
    {16'h0200, 1'b0, 2'd2, 1'b1, 1'b0},
    {16'h13C3, 1'b0, 2'd3, 1'b1, 1'b1},
    {16'h0000, 1'b0, 2'd3, 1'b0, 1'b0}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 acq", 32'(acq_mode), 32'd3);
    chk("R1 test", 32'(test_mode), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 pulses", {fifo_clr, dig_rst, fifo_we}, 0);

    // R2 R3 R4 R5 R8 via table
    for (int i = 0; i < NV; i++) begin
      cyc(1, 0, 2'd0, VEC[i][20:5], 0, '0);
      chk("R2/R3 test (R4 R5 R8)", 32'(test_mode), 32'(VEC[i][4]));
      chk("R4 acq (R5 R8)", 32'(acq_mode), 32'(VEC[i][3:2]));
      chk("R2/R3 clr (R4 R8)", 32'(fifo_clr), 32'(VEC[i][1]));
      chk("R4 rst (R2 R3 R8)", 32'(dig_rst), 32'(VEC[i][0]));
      @(negedge clk);
      chk("R4 single pulse", {fifo_clr, dig_rst}, 0);
    end

    // R9 digitiser path
    cyc(0, 0, 2'd0, 0, 1, 32'hDEADBEEF);
    chk("R9 we", 32'(fifo_we), 1);
    chk("R9 data", fifo_wdata, 32'hDEADBEEF);
    cyc(1, 0, 2'd2, 16'hAAAA, 0, '0);
    chk("R9 bus push ignored", 32'(fifo_we), 0);

    // R11 clear races digitiser word
    cyc(1, 0, 2'd0, 16'h1100, 1, 32'h01234567);
    chk("R11 clr", 32'(fifo_clr), 1);
    chk("R11 dropped", 32'(fifo_we), 0);
    chk("R11 acq", 32'(acq_mode), 1);

    // R10 test word path
    cyc(1, 0, 2'd0, 16'h0100, 0, '0);
    cyc(1, 0, 2'd1, 16'h1234, 0, '0);
    chk("R10 hi no push", 32'(fifo_we), 0);
    cyc(1, 0, 2'd2, 16'h5678, 0, '0);
    chk("R10 we", 32'(fifo_we), 1);
    chk("R10 data", fifo_wdata, 32'h12345678);
    cyc(0, 0, 2'd0, 0, 1, 32'hCAFEF00D);
    chk("R10 dig dropped", 32'(fifo_we), 0);

    // R6 R7 status handshake
    chk("R6 rdata idle", 32'(bus_rdata), 0);
    cyc(1, 0, 2'd0, 16'h0300, 0, '0);
    chk("R6 busy", 32'(busy), 1);
    cyc(1, 0, 2'd0, 16'h1000, 0, '0);
    chk("R7 acq held", 32'(acq_mode), 1);
    chk("R7 no pulse", {fifo_clr, dig_rst}, 0);
    cyc(1, 0, 2'd0, 16'h0200, 0, '0);
    chk("R7 test held", 32'(test_mode), 1);
    chk("R6 still busy", 32'(busy), 1);
    @(negedge clk);
    bus_rd = 1; bus_addr = 2'd0; bus_wr = 1; bus_wdata = 16'h0200;
    #1 chk("R6 reply", 32'(bus_rdata), 32'h1);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    chk("R6 released", 32'(busy), 0);
    chk("R7 write at release ignored", 32'(test_mode), 1);
    chk("R7 no clr at release", 32'(fifo_clr), 0);
    cyc(1, 0, 2'd0, 16'h0200, 0, '0);
    cyc(1, 0, 2'd0, 16'h03FF, 0, '0);
    @(negedge clk);
    bus_rd = 1; bus_addr = 2'd0;
    #1 chk("R6 reply off", 32'(bus_rdata), 0);
    @(negedge clk);
    bus_rd = 0;
    chk("R6 released again", 32'(busy), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule